// File: doc/BRIEF.md
# Victim Line Buffer with Idle-Bus Writeback

This block sits between a write-back L2 cache and the memory bus. Every line the L2 throws out is written into one of six slots, whether clean or modified. The L2 can then take its refill at once and never waits for a memory write. Each slot keeps a valid flag, a dirty flag, the line tag, the full line and an age rank. When the L2 misses, it presents the tag here. All slots are compared in parallel, and a hit returns the line and its dirty flag combinationally in the same cycle.

A hit hands the line back to the L2 and frees the slot, so a line never lives in both places. Modified slots are written to memory by a small drain machine, oldest first. A drain starts only when the bus reports idle. The only exception is a full buffer with every slot dirty while an eviction waits. In that case the oldest dirty slot is written at once and the eviction port stalls.

The drain machine has three states. DR_IDLE moves to DR_DRAIN when the bus is idle, a dirty slot exists and no lookup hits in that cycle. DR_IDLE moves to DR_FORCE when an eviction is stalled because all six slots are dirty. DR_DRAIN and DR_FORCE both return to DR_IDLE on the cycle the memory acknowledges the write.

Top module: `victim_buffer`

## Requirements
- R1: After reset all slots are empty, `evict_ready` is high, `mem_wr_valid` is low and no lookup hits.
- R2: A lookup whose tag matches a valid slot raises `resp_hit` in the same cycle, with that slot's line on `resp_data` and its dirty flag on `resp_dirty`. A lookup with no matching slot leaves `resp_hit` low.
- R3: A lookup hit on a slot that is not being written frees that slot at the next clock edge, so a repeated lookup of the same tag misses.
- R4: An eviction is accepted (`evict_ready` high) whenever its tag matches a slot, a slot is free, or a clean slot exists, provided the matching slot is not under writeback.
- R5: An eviction whose tag is already held overwrites that slot and does not create a second copy. The new dirty flag is the OR of the old and the incoming flags.
- R6: With all slots valid and at least one clean, a new eviction overwrites the oldest clean slot.
- R7: With all slots valid and dirty, an eviction that does not match a held tag sees `evict_ready` low. The oldest dirty slot is written at once, regardless of `mem_idle`. The eviction is accepted in the cycle after the acknowledge and takes that slot.
- R8: An opportunistic write starts only after a cycle in which `mem_idle` is high. Dirty slots are written in the order they were inserted, oldest first.
- R9: `mem_wr_valid`, `mem_wr_tag` and `mem_wr_data` hold steady until `mem_wr_ack`. The slot's dirty flag clears only at the acknowledge, and a later hit reports it clean.
- R10: A lookup hit on the slot under writeback returns its line with `resp_dirty` low. The slot stays readable until the acknowledge and is freed then.
- R11: An eviction whose tag matches the slot under writeback is stalled until that write finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_valid | input | 1 | L2 offers an evicted line |
| evict_ready | output | 1 | Buffer accepts the offered line this cycle |
| evict_tag | input | TAG_W | Tag of the evicted line |
| evict_data | input | LINE_W | Evicted line contents |
| evict_dirty | input | 1 | Evicted line is modified |
| lookup_valid | input | 1 | L2 miss probe is present |
| lookup_tag | input | TAG_W | Tag being probed |
| resp_hit | output | 1 | Probe matched a held line (same cycle) |
| resp_data | output | LINE_W | Line returned on a hit |
| resp_dirty | output | 1 | Returned line still needs writeback |
| mem_idle | input | 1 | Memory bus has a free cycle |
| mem_wr_valid | output | 1 | Line write to memory is pending |
| mem_wr_tag | output | TAG_W | Tag of the line being written |
| mem_wr_data | output | LINE_W | Line being written |
| mem_wr_ack | input | 1 | Memory accepted the write |

## Verification
The hardest situation to reach is a full buffer in which every slot is dirty and an eviction is waiting. Only there does the machine write regardless of bus state and hold the eviction port low. The stimulus keeps `mem_idle` low so nothing drains, then fills the slots with a mix of clean and dirty lines. It shows a clean slot being displaced, frees one with a lookup, and refills it dirty. A further eviction then must stall, force out the oldest line and land in that slot after the acknowledge. A second hard case is a lookup that lands on the slot under writeback: the bench holds back the acknowledge for several cycles while probing and re-evicting that tag.

// File: rtl/victim_pkg.sv
package victim_pkg;

    typedef enum logic [1:0] {
        DR_IDLE  = 2'd0,
        DR_DRAIN = 2'd1,
        DR_FORCE = 2'd2
    } drain_state_e;

endpackage

// File: rtl/victim_match.sv
module victim_match #(
    parameter int N     = 6,
    parameter int TAG_W = 26,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [N-1:0]            valid,
    input  logic [TAG_W-1:0]        key,
    output logic [N-1:0]            hit_vec,
    output logic                    any_hit,
    output logic [IDX_W-1:0]        hit_idx
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        any_hit = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i] && !any_hit) begin
                any_hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/victim_oldest.sv
module victim_oldest #(
    parameter int N     = 6,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            cand,
    input  logic [N-1:0][IDX_W-1:0] rank,
    output logic                    found,
    output logic [IDX_W-1:0]        idx
);

    logic [IDX_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || rank[i] > best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = rank[i];
            end
        end
    end

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
    import victim_pkg::*;
#(
    parameter int ENTRIES = 6,
    parameter int TAG_W   = 26,
    parameter int LINE_W  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evict_valid,
    output logic              evict_ready,
    input  logic [TAG_W-1:0]  evict_tag,
    input  logic [LINE_W-1:0] evict_data,
    input  logic              evict_dirty,
    input  logic              lookup_valid,
    input  logic [TAG_W-1:0]  lookup_tag,
    output logic              resp_hit,
    output logic [LINE_W-1:0] resp_data,
    output logic              resp_dirty,
    input  logic              mem_idle,
    output logic              mem_wr_valid,
    output logic [TAG_W-1:0]  mem_wr_tag,
    output logic [LINE_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef logic [ENTRIES-1:0][IDX_W-1:0] rank_t;

    // slot storage
    logic [ENTRIES-1:0]             valid_q, dirty_q;
    logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0]              data_q [ENTRIES];
    rank_t                          rank_q;

    logic [ENTRIES-1:0]             valid_n, dirty_n;
    rank_t                          rank_n;

    // drain machine
    drain_state_e                   state_q, state_d;
    logic [IDX_W-1:0]               wr_idx_q, wr_idx_d;
    logic                           drop_q, drop_d;

    // search results
    logic [ENTRIES-1:0]             lk_vec, ev_vec;
    logic                           lk_any, ev_any;
    logic [IDX_W-1:0]               lk_idx, ev_idx;
    logic                           od_found, oc_found;
    logic [IDX_W-1:0]               od_idx, oc_idx;
    logic                           free_found;
    logic [IDX_W-1:0]               free_idx;

    logic                           inflight, lk_hit, lk_on_inflight, ev_on_inflight;
    logic                           ev_fire, ev_stalled, wr_done;
    logic [IDX_W-1:0]               ev_slot;

    victim_match #(.N(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_lk_match (
        .tags(tag_q), .valid(valid_q), .key(lookup_tag),
        .hit_vec(lk_vec), .any_hit(lk_any), .hit_idx(lk_idx)
    );

    victim_match #(.N(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_ev_match (
        .tags(tag_q), .valid(valid_q), .key(evict_tag),
        .hit_vec(ev_vec), .any_hit(ev_any), .hit_idx(ev_idx)
    );

    victim_oldest #(.N(ENTRIES), .IDX_W(IDX_W)) u_old_dirty (
        .cand(valid_q & dirty_q), .rank(rank_q), .found(od_found), .idx(od_idx)
    );

    victim_oldest #(.N(ENTRIES), .IDX_W(IDX_W)) u_old_clean (
        .cand(valid_q & ~dirty_q), .rank(rank_q), .found(oc_found), .idx(oc_idx)
    );

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_q[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    // port decisions
    assign inflight       = (state_q != DR_IDLE);
    assign lk_hit         = lookup_valid && lk_any;
    assign lk_on_inflight = lk_hit && inflight && (lk_idx == wr_idx_q);
    assign ev_on_inflight = ev_any && inflight && (ev_idx == wr_idx_q);
    assign evict_ready    = !ev_on_inflight && (ev_any || free_found || oc_found);
    assign ev_fire        = evict_valid && evict_ready;
    assign ev_stalled     = evict_valid && !evict_ready && !ev_on_inflight;
    assign ev_slot        = ev_any ? ev_idx : (free_found ? free_idx : oc_idx);
    assign wr_done        = inflight && mem_wr_ack;

    assign resp_hit   = lk_hit;
    assign resp_data  = data_q[lk_idx];
    assign resp_dirty = lk_hit && dirty_q[lk_idx] && !lk_on_inflight;

    // drain machine: next state
    always_comb begin
        state_d  = state_q;
        wr_idx_d = wr_idx_q;
        drop_d   = drop_q;
        unique case (state_q)
            DR_IDLE: begin
                drop_d = 1'b0;
                if (ev_stalled && od_found && !lk_hit) begin
                    state_d  = DR_FORCE;
                    wr_idx_d = od_idx;
                end else if (mem_idle && od_found && !lk_hit) begin
                    state_d  = DR_DRAIN;
                    wr_idx_d = od_idx;
                end
            end
            DR_DRAIN, DR_FORCE: begin
                if (mem_wr_ack) begin
                    state_d = DR_IDLE;
                    drop_d  = 1'b0;
                end else begin
                    drop_d  = drop_q || lk_on_inflight;
                end
            end
            default: state_d = DR_IDLE;
        endcase
    end

    // drain machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= DR_IDLE;
            wr_idx_q <= '0;
            drop_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            wr_idx_q <= wr_idx_d;
            drop_q   <= drop_d;
        end
    end

    // drain machine: outputs
    always_comb begin
        mem_wr_valid = inflight;
        mem_wr_tag   = tag_q[wr_idx_q];
        mem_wr_data  = data_q[wr_idx_q];
    end

    // close the rank gap left by a freed slot
    function automatic rank_t drop_rank(input rank_t r, input logic [ENTRIES-1:0] v,
                                        input logic [IDX_W-1:0] k);
        rank_t o;
        o = r;
        for (int j = 0; j < ENTRIES; j++) begin
            if (v[j] && r[j] > r[k]) o[j] = r[j] - 1'b1;
        end
        return o;
    endfunction

    // slot flag and age update: frees first, then the insertion
    always_comb begin
        logic old_live;
        valid_n  = valid_q;
        dirty_n  = dirty_q;
        rank_n   = rank_q;
        old_live = 1'b0;
        if (lk_hit && !lk_on_inflight) begin
            rank_n          = drop_rank(rank_n, valid_n, lk_idx);
            valid_n[lk_idx] = 1'b0;
            dirty_n[lk_idx] = 1'b0;
        end
        if (wr_done) begin
            if (drop_q || lk_on_inflight) begin
                rank_n            = drop_rank(rank_n, valid_n, wr_idx_q);
                valid_n[wr_idx_q] = 1'b0;
            end
            dirty_n[wr_idx_q] = 1'b0;
        end
        if (ev_fire) begin
            old_live = valid_n[ev_slot];
            for (int j = 0; j < ENTRIES; j++) begin
                if (IDX_W'(j) != ev_slot && valid_n[j] &&
                    (!old_live || rank_n[j] < rank_n[ev_slot]))
                    rank_n[j] = rank_n[j] + 1'b1;
            end
            dirty_n[ev_slot] = evict_dirty || (old_live && dirty_n[ev_slot]);
            valid_n[ev_slot] = 1'b1;
            rank_n[ev_slot]  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            rank_q  <= '0;
            tag_q   <= '0;
            for (int i = 0; i < ENTRIES; i++) data_q[i] <= '0;
        end else begin
            valid_q <= valid_n;
            dirty_q <= dirty_n;
            rank_q  <= rank_n;
            if (ev_fire) begin
                tag_q[ev_slot]  <= evict_tag;
                data_q[ev_slot] <= evict_data;
            end
        end
    end

    // ---------------- assertions ----------------
    assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ack |=> mem_wr_valid && $stable(mem_wr_tag) && $stable(mem_wr_data));

    assert_dirty_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> valid_q[wr_idx_q] && dirty_q[wr_idx_q]);

    assert_drain_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_valid) |-> $past(mem_idle) || $past(evict_valid && !evict_ready));

    assert_no_dup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec) && $onehot0(ev_vec));

    assert_full_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_q) && (&dirty_q) && !ev_any |-> !evict_ready);

    assert_inflight_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit && mem_wr_valid && (mem_wr_tag == lookup_tag) |-> !resp_dirty);

endmodule

// File: tb/test_victim_buffer.sv
`timescale 1ns/1ps
module test_victim_buffer;

    localparam int TW = 8;
    localparam int LW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evict_valid = 1'b0, evict_dirty = 1'b0;
    logic [TW-1:0] evict_tag = '0;
    logic [LW-1:0] evict_data = '0;
    logic evict_ready;
    logic lookup_valid = 1'b0;
    logic [TW-1:0] lookup_tag = '0;
    logic resp_hit, resp_dirty;
    logic [LW-1:0] resp_data;
    logic mem_idle = 1'b0, mem_wr_ack = 1'b0;
    logic mem_wr_valid;
    logic [TW-1:0] mem_wr_tag;
    logic [LW-1:0] mem_wr_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    victim_buffer #(.ENTRIES(6), .TAG_W(TW), .LINE_W(LW)) i_victim_buffer (
        .clk(clk), .rst_n(rst_n),
        .evict_valid(evict_valid), .evict_ready(evict_ready), .evict_tag(evict_tag),
        .evict_data(evict_data), .evict_dirty(evict_dirty),
        .lookup_valid(lookup_valid), .lookup_tag(lookup_tag),
        .resp_hit(resp_hit), .resp_data(resp_data), .resp_dirty(resp_dirty),
        .mem_idle(mem_idle), .mem_wr_valid(mem_wr_valid), .mem_wr_tag(mem_wr_tag),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
    );

    typedef struct packed {
        logic          is_evict;
        logic [7:0]    tag;
        logic [7:0]    fill;
        logic          dirty;
        logic          exp_hit;
        logic          exp_dirty;
        logic [7:0]    exp_fill;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h10, 8'hA1, 1'b1, 1'b0, 1'b0, 8'h00},  // R4 insert dirty
        '{1'b1, 8'h20, 8'hB2, 1'b0, 1'b0, 1'b0, 8'h00},  // R4 insert clean
        '{1'b0, 8'h10, 8'h00, 1'b0, 1'b1, 1'b1, 8'hA1},  // R2 hit dirty
        '{1'b0, 8'h10, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00},  // R3 freed by hit
        '{1'b0, 8'h20, 8'h00, 1'b0, 1'b1, 1'b0, 8'hB2},  // R2 hit clean
        '{1'b0, 8'h30, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00},  // R2 miss
        '{1'b1, 8'h30, 8'hC3, 1'b0, 1'b0, 1'b0, 8'h00},  // R4
        '{1'b1, 8'h30, 8'hC4, 1'b1, 1'b0, 1'b0, 8'h00},  // R5 same tag
        '{1'b0, 8'h30, 8'h00, 1'b0, 1'b1, 1'b1, 8'hC4},  // R5 newest data
        '{1'b0, 8'h30, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00},  // R5 no second copy
        '{1'b1, 8'h90, 8'h91, 1'b1, 1'b0, 1'b0, 8'h00},  // R4
        '{1'b1, 8'h90, 8'h92, 1'b0, 1'b0, 1'b0, 8'h00},  // R5 clean over dirty
        '{1'b0, 8'h90, 8'h00, 1'b0, 1'b1, 1'b1, 8'h92},  // R5 dirty kept
        '{1'b0, 8'h90, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}   // R3
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic evict_one(input logic [7:0] t, input logic [7:0] f, input logic d);
        @(negedge clk);
        evict_valid = 1'b1; evict_tag = t; evict_data = {4{f}}; evict_dirty = d;
        #5 check(evict_ready == 1'b1, "R4", "evict_ready", 64'(evict_ready), 64'd1);
        @(negedge clk);
        evict_valid = 1'b0;
    endtask

    task automatic lookup_chk(input logic [7:0] t, input logic eh, input logic ed,
                              input logic [7:0] ef, input string req);
        @(negedge clk);
        lookup_valid = 1'b1; lookup_tag = t;
        #5 check(resp_hit == eh, req, "resp_hit", 64'(resp_hit), 64'(eh));
        if (eh) begin
            check(resp_data == {4{ef}}, req, "resp_data", 64'(resp_data), 64'({4{ef}}));
            check(resp_dirty == ed, req, "resp_dirty", 64'(resp_dirty), 64'(ed));
        end
        @(negedge clk);
        lookup_valid = 1'b0;
    endtask

    task automatic expect_write(input logic [7:0] t, input logic [7:0] f, input string req);
        @(negedge clk);
        #5 check(mem_wr_valid == 1'b1, req, "mem_wr_valid", 64'(mem_wr_valid), 64'd1);
        check(mem_wr_tag == t, req, "mem_wr_tag", 64'(mem_wr_tag), 64'(t));
        check(mem_wr_data == {4{f}}, req, "mem_wr_data", 64'(mem_wr_data), 64'({4{f}}));
        mem_wr_ack = 1'b1;
        @(negedge clk);
        mem_wr_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog all: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        lookup_valid = 1'b1; lookup_tag = 8'h10;
        #5 check(evict_ready == 1'b1, "R1", "evict_ready", 64'(evict_ready), 64'd1);
        check(mem_wr_valid == 1'b0, "R1", "mem_wr_valid", 64'(mem_wr_valid), 64'd0);
        check(resp_hit == 1'b0, "R1", "resp_hit", 64'(resp_hit), 64'd0);
        @(negedge clk);
        lookup_valid = 1'b0;

        // vector table, bus kept busy
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (VECS[i].is_evict) begin
                evict_valid = 1'b1; evict_tag = VECS[i].tag;
                evict_data = {4{VECS[i].fill}}; evict_dirty = VECS[i].dirty;
                lookup_valid = 1'b0;
                #5 check(evict_ready == 1'b1, "R4", "table evict_ready", 64'(evict_ready), 64'd1);
            end else begin
                evict_valid = 1'b0;
                lookup_valid = 1'b1; lookup_tag = VECS[i].tag;
                #5 check(resp_hit == VECS[i].exp_hit, "R2", "table resp_hit",
                         64'(resp_hit), 64'(VECS[i].exp_hit));
                if (VECS[i].exp_hit) begin
                    check(resp_data == {4{VECS[i].exp_fill}}, "R2", "table resp_data",
                          64'(resp_data), 64'({4{VECS[i].exp_fill}}));
                    check(resp_dirty == VECS[i].exp_dirty, "R2", "table resp_dirty",
                          64'(resp_dirty), 64'(VECS[i].exp_dirty));
                end
            end
        end
        @(negedge clk);
        evict_valid = 1'b0; lookup_valid = 1'b0;

        // R8: no write while bus busy, then one idle cycle starts it
        evict_one(8'h40, 8'h44, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #5 check(mem_wr_valid == 1'b0, "R8", "write while busy", 64'(mem_wr_valid), 64'd0);
        end
        @(negedge clk);
        mem_idle = 1'b1;
        @(negedge clk);
        mem_idle = 1'b0;
        #5 check(mem_wr_valid == 1'b1, "R8", "write after idle", 64'(mem_wr_valid), 64'd1);
        check(mem_wr_tag == 8'h40, "R8", "write tag", 64'(mem_wr_tag), 64'h40);
        // R9 hold, R11 stall on same tag
        @(negedge clk);
        evict_valid = 1'b1; evict_tag = 8'h40; evict_data = {4{8'h4F}}; evict_dirty = 1'b1;
        #5 check(mem_wr_valid == 1'b1 && mem_wr_tag == 8'h40, "R9", "write held",
                 64'(mem_wr_tag), 64'h40);
        check(evict_ready == 1'b0, "R11", "evict same tag in flight", 64'(evict_ready), 64'd0);
        @(negedge clk);
        evict_valid = 1'b0;
        // R10 hit during writeback
        lookup_chk(8'h40, 1'b1, 1'b0, 8'h44, "R10");
        lookup_chk(8'h40, 1'b1, 1'b0, 8'h44, "R10");
        @(negedge clk);
        mem_wr_ack = 1'b1;
        @(negedge clk);
        mem_wr_ack = 1'b0;
        #5 check(mem_wr_valid == 1'b0, "R9", "write ends at ack", 64'(mem_wr_valid), 64'd0);
        lookup_chk(8'h40, 1'b0, 1'b0, 8'h00, "R10");

        // R8 oldest first, R9 dirty clears at ack
        evict_one(8'h61, 8'h61, 1'b1);
        evict_one(8'h62, 8'h62, 1'b1);
        evict_one(8'h63, 8'h63, 1'b1);
        @(negedge clk);
        mem_idle = 1'b1;
        expect_write(8'h61, 8'h61, "R8");
        expect_write(8'h62, 8'h62, "R8");
        expect_write(8'h63, 8'h63, "R8");
        mem_idle = 1'b0;
        lookup_chk(8'h61, 1'b1, 1'b0, 8'h61, "R9");
        lookup_chk(8'h62, 1'b1, 1'b0, 8'h62, "R9");
        lookup_chk(8'h63, 1'b1, 1'b0, 8'h63, "R9");

        // R6 oldest clean displaced
        evict_one(8'h70, 8'h70, 1'b0);
        evict_one(8'h71, 8'h71, 1'b1);
        evict_one(8'h72, 8'h72, 1'b0);
        evict_one(8'h73, 8'h73, 1'b1);
        evict_one(8'h74, 8'h74, 1'b1);
        evict_one(8'h75, 8'h75, 1'b1);
        evict_one(8'h80, 8'h80, 1'b1);
        lookup_chk(8'h70, 1'b0, 1'b0, 8'h00, "R6");
        lookup_chk(8'h72, 1'b1, 1'b0, 8'h72, "R6");

        // R7 all dirty: stall and forced write
        evict_one(8'h81, 8'h81, 1'b1);
        @(negedge clk);
        evict_valid = 1'b1; evict_tag = 8'h82; evict_data = {4{8'h82}}; evict_dirty = 1'b1;
        #5 check(evict_ready == 1'b0, "R7", "stall when all dirty", 64'(evict_ready), 64'd0);
        check(mem_wr_valid == 1'b0, "R7", "no write yet", 64'(mem_wr_valid), 64'd0);
        @(negedge clk);
        #5 check(mem_wr_valid == 1'b1, "R7", "forced write", 64'(mem_wr_valid), 64'd1);
        check(mem_wr_tag == 8'h71, "R7", "forced oldest tag", 64'(mem_wr_tag), 64'h71);
        check(evict_ready == 1'b0, "R7", "still stalled", 64'(evict_ready), 64'd0);
        mem_wr_ack = 1'b1;
        @(negedge clk);
        mem_wr_ack = 1'b0;
        #5 check(evict_ready == 1'b1, "R7", "ready after ack", 64'(evict_ready), 64'd1);
        @(negedge clk);
        evict_valid = 1'b0;
        lookup_chk(8'h71, 1'b0, 1'b0, 8'h00, "R7");
        lookup_chk(8'h82, 1'b1, 1'b1, 8'h82, "R7");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule